// File: doc/BRIEF.md
# SD Host Error Interrupt Status Register

This block keeps the sticky error flags of an SD host controller. Engines elsewhere in the controller raise one-cycle error pulses: the command path, the data path, the scatter-gather DMA engine, the sampling-tuning logic, the response checker, the system-bus master and the card power monitor. Each pulse latches into its own flag. The flag stays set until software writes a 1 to that bit position. A flag that is set and enabled by a per-bit signal-enable vector drives the combined error interrupt line.

The block also holds a small auto-command sub-status register. That register collects error pulses from the automatic stop and block-count command logic. The auto-command summary flag sets only on a 0-to-1 transition of a counted sub-status bit. Sub-status bit 7 counts only while the active automatic command is the stop command. When software clears the summary flag, the sub-status register is cleared with it. A parameter removes the card power-fail flag for controllers without current limiting.

The register port is a plain single-cycle port. A write takes effect at the clock edge. Read data is combinational from the selected address and the current state. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `sd_err_stat`

## Requirements
- R1: After reset every flag and every sub-status bit is 0. Both register addresses read 0 and `err_irq_o` is 0.
- R2: A one-cycle pulse on an event input sets its flag at the next clock edge, and the flag stays set. Flag positions in the status word (address 0): 0 command timeout, 1 command CRC, 2 command end bit, 3 command index, 4 data timeout, 5 data CRC, 6 data end bit, 7 power fail, 8 auto-command summary, 9 DMA, 10 tuning, 11 response, 12 system-bus error. `cmd_err_i[3:0]` drives bits 3..0 and `dat_err_i[2:0]` drives bits 6..4.
- R3: A write to address 0 clears each flag whose `reg_wdata_i` bit is 1. Flags whose data bit is 0 are unchanged.
- R4: When an event and a write-1 clear reach the same flag in the same cycle, the flag ends up set. This also applies to a sub-status bit whose event coincides with a clear of bit 8.
- R5: Bits 15:13 of address 0 and bits 15:8 of address 1 always read 0, even after writes of 1 to them.
- R6: The response flag (bit 11) sets from `resp_err_i` only when `resp_chk_en_i` is 1 in the same cycle.
- R7: When `HAS_CURR_LIMIT` is 0, bit 7 reads 0 at all times and never contributes to `err_irq_o`.
- R8: `ac_err_i[k]` sets sub-status bit k (address 1). Bit 6 is not implemented and reads 0. Bit 8 of address 0 sets in the same edge as a sub-status bit among 0..5 goes from 0 to 1. A repeated pulse on a sub-status bit that is already 1 does not set bit 8.
- R9: Sub-status bit 7 sets bit 8 on its 0-to-1 transition only if `ac_cmd12_i` is 1 in that cycle. Otherwise bit 7 latches without setting bit 8.
- R10: Clearing bit 8 by a write to address 0 clears the whole sub-status register at the same edge. Writes to address 1 have no effect.
- R11: `err_irq_o` is 1 exactly when some flag is set and its bit in `sig_en_i` is 1.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_err_i | input | 4 | Command-path error pulses (timeout, CRC, end bit, index) |
| dat_err_i | input | 3 | Data-path error pulses (timeout, CRC, end bit) |
| pwr_fail_i | input | 1 | Card power-fail pulse |
| dma_err_i | input | 1 | DMA engine error pulse |
| tune_err_i | input | 1 | Tuning circuit error pulse |
| resp_err_i | input | 1 | Response check error pulse |
| resp_chk_en_i | input | 1 | Response checking enabled |
| bus_err_i | input | 1 | System-bus master error pulse |
| ac_err_i | input | 8 | Auto-command sub-status error pulses |
| ac_cmd12_i | input | 1 | Active automatic command is the stop command |
| reg_addr_i | input | 1 | Register select: 0 status, 1 auto-command sub-status |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data (1 = clear) |
| reg_rdata_o | output | 16 | Read data of the selected register |
| sig_en_i | input | 13 | Per-flag interrupt signal enable |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The assertions check the per-cycle rules on every cycle. These are: a pulse sets its flag at the next edge, a clear without a coinciding event drops the flag, and no flag falls without a write. They also check the response gating, the reserved read-zero bits, the tied-off power flag, the sub-status wipe on clearing bit 8, and a silent interrupt when all enables are 0. Some behaviours need a sequence of cycles and only the bench scenarios can show them. These are the edge-versus-level rule of the summary flag when a sub-status bit pulses again, the stop-command qualification of sub-status bit 7 across a change of `ac_cmd12_i`, set-over-clear races on flags and sub-status, and interrupt selection by individual enable bits.

// File: rtl/sd_err_pkg.sv
package sd_err_pkg;
  localparam int NUM_FLAGS = 13;
  localparam int REG_W     = 16;
  localparam int AC_W      = 8;

  localparam int F_CMD_TO   = 0;
  localparam int F_DAT_TO   = 4;
  localparam int F_PWR      = 7;
  localparam int F_AUTO     = 8;
  localparam int F_DMA      = 9;
  localparam int F_TUNE     = 10;
  localparam int F_RESP     = 11;
  localparam int F_BUS      = 12;

  // sub-status bits that exist (bit 6 absent)
  localparam logic [AC_W-1:0] AC_IMPL      = 8'hBF;
  // sub-status bits that always count toward the summary flag
  localparam logic [AC_W-1:0] AC_CNT_BASE  = 8'h3F;
  localparam int              AC_STOP_BIT  = 7;

  typedef enum logic {REG_ERR = 1'b0, REG_AC = 1'b1} reg_sel_e;
endpackage

// File: rtl/sd_err_flag_bank.sv
module sd_err_flag_bank #(
  parameter int              W    = 13,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      // set has priority over a same-cycle clear
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i[i] | (q & ~clr_i[i]);
      end
      assign flag_o[i] = q;
    end else begin : g_tie
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sd_err_autocmd.sv
module sd_err_autocmd
  import sd_err_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AC_W-1:0] ac_err_i,
  input  logic            cmd12_i,
  input  logic            clr_i,
  output logic [AC_W-1:0] sub_o,
  output logic            rise_o
);
  logic [AC_W-1:0] sub_q, base, nxt, cnt_mask;

  always_comb begin
    cnt_mask = AC_CNT_BASE;
    cnt_mask[AC_STOP_BIT] = cmd12_i;
    base   = clr_i ? '0 : sub_q;
    nxt    = base | (ac_err_i & AC_IMPL);
    rise_o = |(nxt & ~base & cnt_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= nxt;
  end

  assign sub_o = sub_q;
endmodule

// File: rtl/sd_err_stat.sv
module sd_err_stat
  import sd_err_pkg::*;
#(
  parameter bit HAS_CURR_LIMIT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           cmd_err_i,
  input  logic [2:0]           dat_err_i,
  input  logic                 pwr_fail_i,
  input  logic                 dma_err_i,
  input  logic                 tune_err_i,
  input  logic                 resp_err_i,
  input  logic                 resp_chk_en_i,
  input  logic                 bus_err_i,
  input  logic [AC_W-1:0]      ac_err_i,
  input  logic                 ac_cmd12_i,
  input  logic                 reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_FLAGS-1:0] sig_en_i,
  output logic                 err_irq_o
);
  localparam logic [NUM_FLAGS-1:0] IMPL =
    HAS_CURR_LIMIT ? {NUM_FLAGS{1'b1}} : ~(NUM_FLAGS'(1) << F_PWR);

  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags;
  logic [AC_W-1:0]      ac_sub;
  logic                 ac_rise;

  always_comb begin
    clr_vec = (reg_wr_i && reg_addr_i == REG_ERR) ? reg_wdata_i[NUM_FLAGS-1:0] : '0;
    set_vec = '0;
    set_vec[F_CMD_TO +: 4] = cmd_err_i;
    set_vec[F_DAT_TO +: 3] = dat_err_i;
    set_vec[F_PWR]         = pwr_fail_i;
    set_vec[F_AUTO]        = ac_rise;
    set_vec[F_DMA]         = dma_err_i;
    set_vec[F_TUNE]        = tune_err_i;
    set_vec[F_RESP]        = resp_err_i & resp_chk_en_i;
    set_vec[F_BUS]         = bus_err_i;
  end

  sd_err_autocmd u_ac (
    .clk      (clk),
    .rst_n    (rst_n),
    .ac_err_i (ac_err_i),
    .cmd12_i  (ac_cmd12_i),
    .clr_i    (clr_vec[F_AUTO]),
    .sub_o    (ac_sub),
    .rise_o   (ac_rise)
  );

  sd_err_flag_bank #(.W(NUM_FLAGS), .IMPL(IMPL)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flags)
  );

  always_comb begin
    if (reg_addr_i == REG_ERR) reg_rdata_o = REG_W'(flags);
    else                       reg_rdata_o = REG_W'(ac_sub);
  end

  assign err_irq_o = |(flags & sig_en_i);
endmodule

// File: rtl/sd_err_stat_chk.sv
module sd_err_stat_chk
  import sd_err_pkg::*;
#(
  parameter bit HAS_CURR_LIMIT = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           cmd_err_i,
  input logic                 resp_err_i,
  input logic                 resp_chk_en_i,
  input logic [AC_W-1:0]      ac_err_i,
  input logic                 reg_addr_i,
  input logic                 reg_wr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [REG_W-1:0]     reg_rdata_o,
  input logic [NUM_FLAGS-1:0] sig_en_i,
  input logic                 err_irq_o,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [AC_W-1:0]      ac_sub
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_i[0] |=> flags[0]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 1'b0 && reg_wdata_i[0] && !cmd_err_i[0]) |=> !flags[0]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> ((flags & $past(flags)) == $past(flags)));

  p_race_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err_i[1] && reg_wr_i && reg_addr_i == 1'b0 && reg_wdata_i[1]) |=> flags[1]);

  p_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 1'b0) |-> (reg_rdata_o[15:13] == 3'b000));

  p_resp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[F_RESP] && !resp_chk_en_i) |=> !flags[F_RESP]);

  p_no_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_CURR_LIMIT |-> !flags[F_PWR]);

  p_ac_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_err_i[0] && !ac_sub[0]) |=> flags[F_AUTO]);

  p_ac_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 1'b0 && reg_wdata_i[F_AUTO] && ac_err_i == '0) |=> (ac_sub == '0));

  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en_i == '0) |-> !err_irq_o);
endmodule

bind sd_err_stat sd_err_stat_chk #(.HAS_CURR_LIMIT(HAS_CURR_LIMIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_err_i     (cmd_err_i),
  .resp_err_i    (resp_err_i),
  .resp_chk_en_i (resp_chk_en_i),
  .ac_err_i      (ac_err_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wr_i      (reg_wr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .sig_en_i      (sig_en_i),
  .err_irq_o     (err_irq_o),
  .flags         (flags),
  .ac_sub        (ac_sub)
);

// File: tb/sd_err_stat_test.sv
module sd_err_stat_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // row: {resp_chk_en, wr, event[12:0], wdata[15:0], expected status[15:0]}
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 1'b0, 13'h0001, 16'h0000, 16'h0001},  // R2 cmd timeout
    {1'b0, 1'b0, 13'h0006, 16'h0000, 16'h0007},  // R2 cmd crc/endbit
    {1'b0, 1'b0, 13'h0078, 16'h0000, 16'h007F},  // R2 index + data
    {1'b0, 1'b0, 13'h0080, 16'h0000, 16'h00FF},  // R2 power fail
    {1'b0, 1'b0, 13'h0600, 16'h0000, 16'h06FF},  // R2 dma + tuning
    {1'b0, 1'b0, 13'h1000, 16'h0000, 16'h16FF},  // R2 bus error
    {1'b0, 1'b1, 13'h0000, 16'h0005, 16'h16FA},  // R3 partial clear
    {1'b0, 1'b1, 13'h0000, 16'hE000, 16'h16FA},  // R5 reserved write
    {1'b0, 1'b1, 13'h0001, 16'h0001, 16'h16FB},  // R4 set beats clear
    {1'b0, 1'b1, 13'h0000, 16'h1FFF, 16'h0000},  // R3 clear all
    {1'b0, 1'b0, 13'h0800, 16'h0000, 16'h0000},  // R6 gated off
    {1'b1, 1'b0, 13'h0800, 16'h0000, 16'h0800},  // R6 gated on
    {1'b0, 1'b1, 13'h0000, 16'h0800, 16'h0000}   // R3 clear response
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cmd_err_i = '0;
  logic [2:0] dat_err_i = '0;
  logic pwr_fail_i = 0, dma_err_i = 0, tune_err_i = 0, resp_err_i = 0;
  logic resp_chk_en_i = 0, bus_err_i = 0, ac_cmd12_i = 0;
  logic [7:0] ac_err_i = '0;
  logic reg_addr_i = 0, reg_wr_i = 0;
  logic [15:0] reg_wdata_i = '0;
  logic [12:0] sig_en_i = '0;
  logic [15:0] rdata, rdata_nc;
  logic irq, irq_nc;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_err_stat uut (
    .clk(clk), .rst_n(rst_n), .cmd_err_i(cmd_err_i), .dat_err_i(dat_err_i),
    .pwr_fail_i(pwr_fail_i), .dma_err_i(dma_err_i), .tune_err_i(tune_err_i),
    .resp_err_i(resp_err_i), .resp_chk_en_i(resp_chk_en_i), .bus_err_i(bus_err_i),
    .ac_err_i(ac_err_i), .ac_cmd12_i(ac_cmd12_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(rdata),
    .sig_en_i(sig_en_i), .err_irq_o(irq));

  sd_err_stat #(.HAS_CURR_LIMIT(1'b0)) uut_nocl (
    .clk(clk), .rst_n(rst_n), .cmd_err_i(cmd_err_i), .dat_err_i(dat_err_i),
    .pwr_fail_i(pwr_fail_i), .dma_err_i(dma_err_i), .tune_err_i(tune_err_i),
    .resp_err_i(resp_err_i), .resp_chk_en_i(resp_chk_en_i), .bus_err_i(bus_err_i),
    .ac_err_i(ac_err_i), .ac_cmd12_i(ac_cmd12_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(rdata_nc),
    .sig_en_i(sig_en_i), .err_irq_o(irq_nc));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmd_err_i = '0; dat_err_i = '0; pwr_fail_i = 0; dma_err_i = 0; tune_err_i = 0;
    resp_err_i = 0; resp_chk_en_i = 0; bus_err_i = 0; ac_err_i = '0;
    reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  // inputs set at a negedge; apply one posedge; back at negedge with pulses dropped
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    reg_addr_i = a;
    #1 v = rdata;
  endtask

  task automatic wr0(input logic [15:0] d);
    reg_addr_i = 0; reg_wr_i = 1; reg_wdata_i = d;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 status", v, 16'h0000);
    rd(1, v); chk("R1 substatus", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] r;
      r = VEC[i];
      reg_addr_i    = 0;
      resp_chk_en_i = r[46];
      reg_wr_i      = r[45];
      cmd_err_i     = r[35:32];
      dat_err_i     = r[38:36];
      pwr_fail_i    = r[39];
      dma_err_i     = r[41];
      tune_err_i    = r[42];
      resp_err_i    = r[43];
      bus_err_i     = r[44];
      reg_wdata_i   = r[31:16];
      step();
      rd(0, v); chk($sformatf("table row %0d (R2/R3/R4/R5/R6)", i), v, r[15:0]);
    end

    // R11 interrupt selection
    reg_addr_i = 0; cmd_err_i = 4'b0100; step();
    sig_en_i = 13'h0000; #1 chk("R11 no enable", {15'b0, irq}, 16'h0000);
    sig_en_i = 13'h0004; #1 chk("R11 matching enable", {15'b0, irq}, 16'h0001);
    sig_en_i = 13'h0008; #1 chk("R11 other enable", {15'b0, irq}, 16'h0000);
    sig_en_i = '0;
    wr0(16'h0004);

    // R7 power flag with and without current limiting
    pwr_fail_i = 1; step();
    rd(0, v); chk("R7 supported", v, 16'h0080);
    chk("R7 tied off", rdata_nc, 16'h0000);
    sig_en_i = 13'h0080; #1;
    chk("R7 irq tied off", {15'b0, irq_nc}, 16'h0000);
    chk("R11 irq power", {15'b0, irq}, 16'h0001);
    sig_en_i = '0;
    wr0(16'h0080);

    // R8 sub-status sets summary
    ac_err_i = 8'h01; step();
    rd(1, v); chk("R8 substatus bit0", v, 16'h0001);
    rd(0, v); chk("R8 summary set", v, 16'h0100);
    // R10 clear summary wipes substatus
    wr0(16'h0100);
    rd(1, v); chk("R10 substatus wiped", v, 16'h0000);
    rd(0, v); chk("R10 summary cleared", v, 16'h0000);
    // R8 bit 6 absent
    ac_err_i = 8'h40; step();
    rd(1, v); chk("R8 bit6 absent", v, 16'h0000);
    rd(0, v); chk("R8 bit6 no summary", v, 16'h0000);
    // R9 bit 7 without stop command
    ac_cmd12_i = 0; ac_err_i = 8'h80; step();
    rd(1, v); chk("R9 bit7 latched", v, 16'h0080);
    rd(0, v); chk("R9 bit7 not counted", v, 16'h0000);
    // R8/R9 repeat on set bit: level not edge
    ac_cmd12_i = 1; ac_err_i = 8'h80; step();
    rd(0, v); chk("R8 no rise no summary", v, 16'h0000);
    // R10 write to address 1 ignored
    reg_addr_i = 1; reg_wr_i = 1; reg_wdata_i = 16'hFFFF; step();
    rd(1, v); chk("R10 addr1 write ignored", v, 16'h0080);
    chk("R5 addr1 upper zero", {8'h00, v[15:8]}, 16'h0000);
    // clear via bit 8, then bit 7 rise with stop command counts
    wr0(16'h0100);
    rd(1, v); chk("R10 wipe bit7", v, 16'h0000);
    ac_cmd12_i = 1; ac_err_i = 8'h80; step();
    rd(0, v); chk("R9 bit7 counted", v, 16'h0100);
    ac_cmd12_i = 0;
    wr0(16'h0100);
    // R4 race on sub-status
    ac_err_i = 8'h02; step();
    reg_addr_i = 0; reg_wr_i = 1; reg_wdata_i = 16'h0100; ac_err_i = 8'h02; step();
    rd(1, v); chk("R4 substatus survives clear", v, 16'h0002);
    rd(0, v); chk("R4 summary survives clear", v, 16'h0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule